// File: doc/BRIEF.md
# Dual-Channel Interleaved Sample Output Stage

This block is the digital back end of a matched pair of converters. On every rising clock edge it captures one I word and one Q word together. Each word then passes through its own fixed-latency pipeline and ends in a per-channel output latch. The two latches share a single 8-bit bus.

A select input picks which latch drives the bus. The selection is purely combinational, so select may be tied to the clock: the high phase then shows I and the low phase shows Q. A bus-float input takes the bus off the wire. This is modelled as an output-enable flag that drops while the data word is forced to zero. A sleep input freezes every pipeline stage and latch. After sleep is released, a valid flag stays low until the pipeline has refilled.

Top module: `iqo_interleave_out`

## Requirements
- R1: The I and Q words present at a rising edge are captured at that same edge, and both reach their latches at the same later edge.
- R2: A word captured at rising edge n is held in its channel latch right after edge n+3, as long as no reset or sleep occurs in between.
- R3: Each channel latch takes a new word at every active rising edge, so a stream of distinct words appears as a stream of distinct outputs, one per cycle.
- R4: With `pick_i` at 1 the bus carries the I latch. With `pick_i` at 0 it carries the Q latch.
- R5: A level change on `pick_i` reaches `bus_data` without waiting for a clock edge. With `pick_i` tied to the clock, one clock cycle shows I while the clock is high and Q while it is low.
- R6: While `float_bus` is 1, `bus_oe` is 0 and `bus_data` is 0. While `float_bus` is 0, `bus_oe` is 1.
- R7: Words pass unchanged in straight binary: input bit 0 (the LSB) appears on `bus_data[0]`, and bit 7 (the MSB) appears on `bus_data[7]`.
- R8: At a rising edge where `sleep` is 1, no pipeline stage and no latch changes.
- R9: A rising edge with `sleep` at 1 clears `bus_valid`. After sleep is released, `bus_valid` returns only after four consecutive active edges.
- R10: A rising edge with `rst` at 1 clears every stage, latch and `bus_valid`. After reset, `bus_valid` rises after the fourth active edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock, rising-edge active |
| rst | input | 1 | Synchronous active-high reset |
| sleep | input | 1 | High freezes all stages and latches |
| float_bus | input | 1 | High takes the shared bus off the wire |
| pick_i | input | 1 | Asynchronous channel select: 1 = I, 0 = Q |
| samp_i | input | 8 | I channel sample word |
| samp_q | input | 8 | Q channel sample word |
| bus_data | output | 8 | Shared output word, straight binary |
| bus_oe | output | 1 | Output enable, low while floated |
| bus_valid | output | 1 | High once the pipeline holds fresh samples |

## Verification
Two functions can land in the same clock cycle. One is the latch update at the rising edge. The other is the select switch at the falling edge, when select is tied to the clock. Both phases of one cycle must show the I and Q halves of the same captured pair. To provoke this, the bench ties select to its clock while a stream of distinct pairs flows through. It records the expected pair at the high phase, then judges the low phase against that same record. A separate pass toggles select in the middle of a cycle by hand, and another floats the bus during the stream.

// File: rtl/iqo_pkg.sv
package iqo_pkg;

  localparam int SAMPLE_W = 8;

  typedef enum logic {
    CH_Q = 1'b0,
    CH_I = 1'b1
  } chan_e;

  typedef struct packed {
    logic [SAMPLE_W-1:0] i;
    logic [SAMPLE_W-1:0] q;
  } iq_pair_t;

endpackage

// File: rtl/iqo_lane.sv
module iqo_lane #(
  parameter int W   = 8,
  parameter int LAT = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         hold,
  input  logic [W-1:0] din,
  output logic [W-1:0] latch_q
);

  // stg[0] is the capture register, stg[LAT] is the output latch
  logic [W-1:0] stg [LAT+1];

  always_ff @(posedge clk) begin
    if (rst) begin
      stg[0] <= '0;
    end else if (!hold) begin
      stg[0] <= din;
    end
  end

  for (genvar k = 1; k <= LAT; k++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) begin
        stg[k] <= '0;
      end else if (!hold) begin
        stg[k] <= stg[k-1];
      end
    end
  end

  assign latch_q = stg[LAT];

  AST_SLEEP_HOLD: assert property (@(posedge clk) disable iff (rst)
    ($past(hold) && !$past(rst)) |-> $stable(latch_q)); // R8

endmodule

// File: rtl/iqo_fill.sv
module iqo_fill #(
  parameter int LAT = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic hold,
  output logic full
);

  localparam int CW = $clog2(LAT + 2);
  localparam logic [CW-1:0] FILL_TOP = CW'(LAT + 1);

  logic [CW-1:0] fill;

  always_ff @(posedge clk) begin
    if (rst || hold) begin
      fill <= '0;
    end else if (fill != FILL_TOP) begin
      fill <= fill + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || hold) begin
      full <= 1'b0;
    end else begin
      full <= (fill == FILL_TOP - 1'b1) || (fill == FILL_TOP);
    end
  end

  AST_SLEEP_INVALID: assert property (@(posedge clk) disable iff (rst)
    hold |=> !full); // R9

  AST_FILL_BOUND: assert property (@(posedge clk) disable iff (rst)
    fill <= FILL_TOP); // R10

endmodule

// File: rtl/iqo_interleave_out.sv
module iqo_interleave_out #(
  parameter int W   = iqo_pkg::SAMPLE_W,
  parameter int LAT = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sleep,
  input  logic         float_bus,
  input  logic         pick_i,
  input  logic [W-1:0] samp_i,
  input  logic [W-1:0] samp_q,
  output logic [W-1:0] bus_data,
  output logic         bus_oe,
  output logic         bus_valid
);
  import iqo_pkg::*;

  localparam int NCH = 2;

  logic [W-1:0] ch_in  [NCH];
  logic [W-1:0] ch_lat [NCH];
  logic [W-1:0] mux_w;
  chan_e        sel_ch;

  assign ch_in[CH_I] = samp_i;
  assign ch_in[CH_Q] = samp_q;

  for (genvar c = 0; c < NCH; c++) begin : g_lane
    iqo_lane #(.W(W), .LAT(LAT)) u_lane (
      .clk     (clk),
      .rst     (rst),
      .hold    (sleep),
      .din     (ch_in[c]),
      .latch_q (ch_lat[c])
    );
  end

  iqo_fill #(.LAT(LAT)) u_fill (
    .clk  (clk),
    .rst  (rst),
    .hold (sleep),
    .full (bus_valid)
  );

  // select acts on level, not on an edge
  always_comb begin
    sel_ch = pick_i ? CH_I : CH_Q;
    mux_w  = ch_lat[sel_ch];
  end

  assign bus_data = float_bus ? '0 : mux_w;
  assign bus_oe   = !float_bus;

  if (LAT == 3) begin : g_lat_chk
    AST_LATENCY_I: assert property (@(posedge clk) disable iff (rst)
      bus_valid |-> (ch_lat[CH_I] == $past(samp_i, 4))); // R2
    AST_LATENCY_Q: assert property (@(posedge clk) disable iff (rst)
      bus_valid |-> (ch_lat[CH_Q] == $past(samp_q, 4))); // R1
  end

  AST_FLOAT_QUIET: assert property (@(posedge clk) disable iff (rst)
    float_bus |-> (!bus_oe && bus_data == '0)); // R6

  AST_RESET_CLEAR: assert property (@(posedge clk)
    $past(rst) |-> (!bus_valid && ch_lat[CH_I] == '0 && ch_lat[CH_Q] == '0)); // R10

endmodule

// File: tb/iqo_interleave_out_bench.sv
`timescale 1ns/100ps
module iqo_interleave_out_bench;
  import iqo_pkg::*;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sleep = 1'b0;
  logic       float_bus = 1'b0;
  logic       pick_man = 1'b1;
  logic       tie_sel = 1'b1;
  logic       pick_i;
  logic [7:0] samp_i = '0;
  logic [7:0] samp_q = '0;
  logic [7:0] bus_data;
  logic       bus_oe;
  logic       bus_valid;

  always #2.5 clk = ~clk;
  assign pick_i = tie_sel ? clk : pick_man;

  iqo_interleave_out u_iqo_interleave_out (
    .clk       (clk),
    .rst       (rst),
    .sleep     (sleep),
    .float_bus (float_bus),
    .pick_i    (pick_i),
    .samp_i    (samp_i),
    .samp_q    (samp_q),
    .bus_data  (bus_data),
    .bus_oe    (bus_oe),
    .bus_valid (bus_valid)
  );

  int       n_chk = 0;
  int       n_fail = 0;
  int       seq_k = 0;
  int       ecnt = 0;
  bit       since_slp = 0;
  bit       snap_ok = 0;
  bit       rst_edge = 1;
  bit       slp_edge = 0;
  iq_pair_t snap;
  iq_pair_t sb_q [$];
  logic [7:0] last_i = '0;
  logic [7:0] last_q = '0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // driver: sets inputs for the next edge and pushes the expected pair
  task automatic drive(input bit r, input bit s, input bit f);
    iq_pair_t it;
    rst       = r;
    sleep     = s;
    float_bus = f;
    it.i = 8'(seq_k * 37 + 1);
    it.q = 8'(255 - seq_k * 11);
    samp_i = it.i;
    samp_q = it.q;
    if (!r && !s) begin
      sb_q.push_back(it);
      seq_k++;
      if (sb_q.size() > 8) void'(sb_q.pop_front());
    end
  endtask

  // monitor, high phase
  always @(posedge clk) begin
    #1;
    rst_edge = rst;
    slp_edge = sleep;
    if (rst) begin
      ecnt = 0; since_slp = 0; sb_q.delete();
    end else if (sleep) begin
      ecnt = 0; since_slp = 1;
    end else if (ecnt < 4) begin
      ecnt++;
    end
    chk(bus_valid == (ecnt == 4), since_slp ? "R9" : "R10", bus_valid, ecnt == 4);
    snap_ok = 0;
    if (float_bus) begin
      chk(!bus_oe && bus_data == 8'h00, "R6", {bus_oe, bus_data}, 0);
    end else begin
      chk(bus_oe == 1'b1, "R6", bus_oe, 1);
      if (rst && tie_sel) chk(bus_data == 8'h00, "R10", bus_data, 0);
      if (ecnt == 4 && sb_q.size() >= 4) begin
        snap = sb_q[sb_q.size() - 4];
        snap_ok = 1;
        if (tie_sel) begin
          chk(bus_data == snap.i, "R2 R3 R4", bus_data, snap.i);
          if (snap.i == 8'h01) chk(bus_data[0] == 1'b1 && bus_data[7:1] == 7'd0, "R7", bus_data, 1);
          if (snap.i == 8'h80) chk(bus_data[7] == 1'b1 && bus_data[6:0] == 7'd0, "R7", bus_data, 8'h80);
        end
      end
      if (tie_sel && !rst) begin
        if (sleep) chk(bus_data == last_i, "R8", bus_data, last_i);
        else last_i = bus_data;
      end
    end
  end

  // monitor, low phase
  always @(negedge clk) begin
    #1;
    if (tie_sel && !float_bus && !rst_edge) begin
      if (snap_ok) chk(bus_data == snap.q, "R1 R4 R5", bus_data, snap.q);
      if (slp_edge) chk(bus_data == last_q, "R8", bus_data, last_q);
      else last_q = bus_data;
    end
  end

  task automatic run(input int n, input bit r, input bit s, input bit f);
    for (int c = 0; c < n; c++) begin
      @(posedge clk); #2;
      drive(r, s, f);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired, no requirement finished");
    report();
  end

  initial begin
    run(3, 1, 0, 0);               // reset state, R10
    run(24, 0, 0, 0);              // stream, R1 R2 R3 R4 R5 R7
    run(4, 0, 0, 1);               // floated bus, R6
    run(8, 0, 0, 0);
    tie_sel = 1'b0;                // manual mid-cycle select, R5
    for (int c = 0; c < 4; c++) begin
      @(posedge clk); #2;
      drive(0, 0, 0);
      #1;
      pick_man = 1'b1; #0.2;
      if (snap_ok) chk(bus_data == snap.i, "R5", bus_data, snap.i);
      pick_man = 1'b0; #0.2;
      if (snap_ok) chk(bus_data == snap.q, "R5", bus_data, snap.q);
    end
    @(posedge clk); #2;
    tie_sel = 1'b1;
    drive(0, 0, 0);
    run(4, 0, 0, 0);
    run(5, 0, 1, 0);               // sleep hold, R8 R9
    run(10, 0, 0, 0);              // refill after sleep, R9
    run(2, 1, 0, 0);               // mid-stream reset, R10
    run(10, 0, 0, 0);
    @(posedge clk); #2;
    report();
  end

endmodule